// File: doc/BRIEF.md
# Dual-Stack 16-bit Forth Core

A compact 16-bit processor that treats Forth as its native instruction set. It keeps a program counter, a data stack whose top two cells (T and N) live in registers, and a separate return stack. One internal word-addressed RAM holds both code and data. Every instruction completes in one clock. A call pushes its return address and redirects the program counter in the same cycle. A return costs nothing, because any ALU instruction can also pop the return stack into the program counter.

The ALU instruction is a set of independent fields. One field picks a function. The others choose whether T is copied into N or onto the return stack, whether N is stored at address T, and how far each stack pointer moves. Most primitive Forth words therefore become a single instruction.

Words are loaded through a load port while reset is held. Stores to addresses with the top bit set are diverted to an I/O strobe port and do not reach the RAM.

Top module: `stk16_core`

## Requirements
- R1: While `rst` is high, `pc` reads 0, `tos` reads 0 and both stack pointers are cleared. Words presented on the load port (`ld_en`, `ld_addr`, `ld_data`) are written into RAM while `rst` is high. Execution starts at word 0 on the first clock after `rst` falls.
- R2: An instruction with bit 15 set is a literal. It pushes bits 14:0 zero-extended as the new T, and the old T becomes N.
- R3: Bits 15:13 = 000 is a jump. The PC loads bits 12:0.
- R4: Bits 15:13 = 001 is a conditional jump. It pops T (N becomes T). It branches to bits 12:0 when the popped value was zero, and otherwise continues at PC+1.
- R5: Bits 15:13 = 010 is a call. In one clock it loads the PC with bits 12:0 and pushes PC+1 onto the return stack.
- R6: Bits 15:13 = 011 is an ALU instruction. When its bit 12 is set, the PC takes the return-stack top in that same clock, so a return adds no cycle.
- R7: ALU bits 11:8 select the result written to T: 0 T, 1 N, 2 T+N, 3 T&N, 4 T|N, 5 T^N, 6 ~T, 7 N==T, 8 signed N<T, 9 N>>T[3:0] (logical), 10 T-1, 11 R, 12 RAM[T], 13 N<<T[3:0], 14 data-stack pointer, 15 unsigned N<T. Comparisons give 0xFFFF for true and 0 for false.
- R8: ALU bits 1:0 are a signed data-stack move (01 push, 11 pop one, 10 pop two). A push keeps the old N in the stack body. ALU bit 7 copies the old T into N.
- R9: ALU bits 3:2 are a signed return-stack move. ALU bit 6 writes T to the new return-stack top. Op 11 reads that top back.
- R10: ALU bit 5 writes N to RAM word T when T[15] is 0. Op 12 then returns that word once T has been re-addressed.
- R11: A store with T[15] = 1 leaves RAM untouched. In the next cycle it raises `io_we` for one cycle, with `io_addr` = T[14:0] and `io_wdata` = N.
- R12: Op 14 returns the data-stack pointer, which counts pushes from 0 after reset. Both pointers wrap modulo the stack depth (32), so a pop from empty yields 31.
- R13: One instruction issues per clock. Straight-line code advances the PC by one every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| ld_en | input | 1 | Load-port write enable, honoured while `rst` is high |
| ld_addr | input | 11 | Load-port word address |
| ld_data | input | 16 | Load-port word |
| pc | output | 13 | Program counter |
| tos | output | 16 | Top-of-stack register T |
| io_we | output | 1 | One-cycle I/O write strobe |
| io_addr | output | 15 | I/O address (T[14:0] of the store) |
| io_wdata | output | 16 | I/O write data (N of the store) |

## Verification
The hardest case to reach from the ports is a store that lands in RAM and is read back. The read port is addressed by the next value of T, so the read must follow a cycle that re-addresses T after the write. The directed program therefore stores, pushes the same address as a literal, and only then issues the fetch op.

The zero-cycle return is proven by stepping a call, a literal and a returning ALU word one clock at a time and checking the PC sequence. The I/O diversion is checked by reading RAM word 0 back after a store to 0x8000, whose low address bits alias word 0.

// File: rtl/stk16_pkg.sv
package stk16_pkg;

  typedef enum logic [3:0] {
    OP_T     = 4'd0,
    OP_N     = 4'd1,
    OP_ADD   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_INV   = 4'd6,
    OP_EQ    = 4'd7,
    OP_SLT   = 4'd8,
    OP_SHR   = 4'd9,
    OP_DEC   = 4'd10,
    OP_R     = 4'd11,
    OP_MEM   = 4'd12,
    OP_SHL   = 4'd13,
    OP_DEPTH = 4'd14,
    OP_ULT   = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    K_JMP  = 2'd0,
    K_CJMP = 2'd1,
    K_CALL = 2'd2,
    K_ALU  = 2'd3
  } kind_e;

  // Low 13 bits of an ALU-class instruction
  typedef struct packed {
    logic       ret;
    alu_op_e    op;
    logic       t2n;
    logic       t2r;
    logic       st;
    logic       rsv;
    logic [1:0] rd;
    logic [1:0] dd;
  } alu_fields_t;

endpackage

// File: rtl/stk16_alu.sv
module stk16_alu
  import stk16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] t,
  input  logic [W-1:0] n,
  input  logic [W-1:0] r,
  input  logic [W-1:0] mq,
  input  logic [W-1:0] depth,
  output logic [W-1:0] res
);
  localparam int SHW = $clog2(W);

  always_comb begin
    case (op)
      OP_T:     res = t;
      OP_N:     res = n;
      OP_ADD:   res = t + n;
      OP_AND:   res = t & n;
      OP_OR:    res = t | n;
      OP_XOR:   res = t ^ n;
      OP_INV:   res = ~t;
      OP_EQ:    res = {W{n == t}};
      OP_SLT:   res = {W{$signed(n) < $signed(t)}};
      OP_SHR:   res = n >> t[SHW-1:0];
      OP_DEC:   res = t - W'(1);
      OP_R:     res = r;
      OP_MEM:   res = mq;
      OP_SHL:   res = n << t[SHW-1:0];
      OP_DEPTH: res = depth;
      OP_ULT:   res = {W{n < t}};
      default:  res = t;
    endcase
  end
endmodule

// File: rtl/stk16_lifo.sv
module stk16_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       delta,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     top,
  output logic [W-1:0]     below,
  output logic [$clog2(DEPTH)-1:0] ptr
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  body [DEPTH];
  logic [PW-1:0] ptr_q, ptr_nx;

  assign ptr_nx = ptr_q + {{(PW-2){delta[1]}}, delta};

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_nx;
  end

  always_ff @(posedge clk) begin
    if (wr_en) body[ptr_nx] <= wr_data;
  end

  assign top   = body[ptr_q];
  assign below = body[ptr_q - PW'(1)];
  assign ptr   = ptr_q;
endmodule

// File: rtl/stk16_ram.sv
module stk16_ram #(
  parameter int W  = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  localparam int WORDS = 2 ** AW;

  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/stk16_core.sv
module stk16_core
  import stk16_pkg::*;
#(
  parameter int W      = 16,
  parameter int AW     = 11,
  parameter int DDEPTH = 32,
  parameter int RDEPTH = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_addr,
  input  logic [W-1:0]    ld_data,
  output logic [W-4:0]    pc,
  output logic [W-1:0]    tos,
  output logic            io_we,
  output logic [W-2:0]    io_addr,
  output logic [W-1:0]    io_wdata
);
  localparam int PCW = W - 3;
  localparam int DPW = $clog2(DDEPTH);
  localparam int RPW = $clog2(RDEPTH);

  logic [W-1:0]   insn, mq, t_q, n_q, t_nx, n_nx, alu_res;
  logic [W-1:0]   d_top, d_below, r_top, r_below, r_wd;
  logic [PCW-1:0] pc_q, pc_nx, pc_inc, target;
  logic [DPW-1:0] d_ptr;
  logic [RPW-1:0] r_ptr;
  logic [1:0]     dd, rd;
  logic           d_we, r_we, st_en, is_lit, io_st, ram_st;
  alu_fields_t    f;
  kind_e          kind;

  assign f      = alu_fields_t'(insn[12:0]);
  assign kind   = kind_e'(insn[W-2 -: 2]);
  assign is_lit = insn[W-1];
  assign target = insn[PCW-1:0];
  assign pc_inc = pc_q + PCW'(1);

  stk16_alu #(.W(W)) u_alu (
    .op(f.op), .t(t_q), .n(n_q), .r(r_top), .mq(mq),
    .depth(W'(d_ptr)), .res(alu_res)
  );

  always_comb begin
    pc_nx = pc_inc;
    t_nx  = t_q;
    n_nx  = n_q;
    dd    = 2'b00;
    rd    = 2'b00;
    d_we  = 1'b0;
    r_we  = 1'b0;
    r_wd  = t_q;
    st_en = 1'b0;
    if (is_lit) begin
      t_nx = {1'b0, insn[W-2:0]};
      n_nx = t_q;
      dd   = 2'b01;
      d_we = 1'b1;
    end else begin
      case (kind)
        K_JMP: pc_nx = target;
        K_CJMP: begin
          dd   = 2'b11;
          t_nx = n_q;
          n_nx = d_top;
          if (t_q == '0) pc_nx = target;
        end
        K_CALL: begin
          rd    = 2'b01;
          r_we  = 1'b1;
          r_wd  = W'(pc_inc);
          pc_nx = target;
        end
        default: begin
          t_nx  = alu_res;
          dd    = f.dd;
          rd    = f.rd;
          if (f.t2n)            n_nx = t_q;
          else if (dd == 2'b11) n_nx = d_top;
          else if (dd == 2'b10) n_nx = d_below;
          d_we  = (dd == 2'b01);
          r_we  = f.t2r;
          st_en = f.st;
          if (f.ret) pc_nx = r_top[PCW-1:0];
        end
      endcase
    end
  end

  assign io_st  = st_en &&  t_q[W-1];
  assign ram_st = st_en && !t_q[W-1];

  stk16_lifo #(.W(W), .DEPTH(DDEPTH)) u_dstk (
    .clk(clk), .rst(rst), .delta(dd), .wr_en(d_we && !rst), .wr_data(n_q),
    .top(d_top), .below(d_below), .ptr(d_ptr)
  );

  stk16_lifo #(.W(W), .DEPTH(RDEPTH)) u_rstk (
    .clk(clk), .rst(rst), .delta(rd), .wr_en(r_we && !rst), .wr_data(r_wd),
    .top(r_top), .below(r_below), .ptr(r_ptr)
  );

  stk16_ram #(.W(W), .AW(AW)) u_ram (
    .clk(clk),
    .we(rst ? ld_en : ram_st),
    .waddr(rst ? ld_addr : t_q[AW-1:0]),
    .wdata(rst ? ld_data : n_q),
    .raddr_a(rst ? '0 : pc_nx[AW-1:0]),
    .rdata_a(insn),
    .raddr_b(rst ? '0 : t_nx[AW-1:0]),
    .rdata_b(mq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      t_q      <= '0;
      n_q      <= '0;
      io_we    <= 1'b0;
      io_addr  <= '0;
      io_wdata <= '0;
    end else begin
      pc_q     <= pc_nx;
      t_q      <= t_nx;
      n_q      <= n_nx;
      io_we    <= io_st;
      io_addr  <= t_q[W-2:0];
      io_wdata <= n_q;
    end
  end

  assign pc  = pc_q;
  assign tos = t_q;

  logic unused_bits;
  assign unused_bits = ^{f.rsv, r_below, r_ptr, pc_nx[PCW-1:AW]};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && t_q == '0));

  // R2
  lit_push_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(is_lit)) |-> (t_q == {1'b0, $past(insn[W-2:0])} && n_q == $past(t_q)));

  // R4
  cjmp_target_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!is_lit && kind == K_CJMP)) |->
      (pc_q == (($past(t_q) == '0) ? $past(target) : $past(pc_inc))));

  // R5
  call_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!is_lit && kind == K_CALL)) |->
      (pc_q == $past(target) && r_top[PCW-1:0] == $past(pc_inc)));

  // R6
  ret_fold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!is_lit && kind == K_ALU && f.ret)) |->
      (pc_q == $past(r_top[PCW-1:0])));

  // R11
  io_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(io_st)) |-> (io_we && io_wdata == $past(n_q)));
endmodule

// File: tb/tb_stk16_core.sv
module tb_stk16_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [10:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [12:0] pc;
  logic [15:0] tos;
  logic        io_we;
  logic [14:0] io_addr;
  logic [15:0] io_wdata;

  stk16_core dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc(pc), .tos(tos), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int plen  = 0;
  logic [15:0] prog [0:31];
  int          io_cnt = 0;
  logic [14:0] io_a;
  logic [15:0] io_d;

  always @(negedge clk) begin
    if (io_we) begin
      io_cnt = io_cnt + 1;
      io_a   = io_addr;
      io_d   = io_wdata;
    end
  end

  function automatic logic [15:0] lit(input logic [14:0] v);
    return {1'b1, v};
  endfunction
  function automatic logic [15:0] jmp(input logic [12:0] a);
    return {3'b000, a};
  endfunction
  function automatic logic [15:0] cjmp(input logic [12:0] a);
    return {3'b001, a};
  endfunction
  function automatic logic [15:0] call(input logic [12:0] a);
    return {3'b010, a};
  endfunction
  function automatic logic [15:0] alu(input logic [3:0] op, input logic ret, input logic tn,
                                      input logic tr, input logic st,
                                      input logic [1:0] rd, input logic [1:0] dd);
    return {3'b011, ret, op, tn, tr, st, 1'b0, rd, dd};
  endfunction

  task automatic emit(input logic [15:0] w);
    prog[plen] = w;
    plen = plen + 1;
  endtask

  task automatic push_val(input logic [15:0] v);
    if (v[15]) begin
      emit(lit(~v[14:0]));
      emit(alu(4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00));
    end else begin
      emit(lit(v[14:0]));
    end
  endtask

  task automatic load_prog();
    rst = 1'b1;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 11'(i); ld_data = prog[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int ncyc);
    load_prog();
    rst = 1'b0;
    repeat (ncyc) @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // {op, N, T, expected}  (R7)
  localparam logic [51:0] VEC [16] = '{
    {4'd2,  16'h0003, 16'h0004, 16'h0007},
    {4'd2,  16'hFFFF, 16'h0001, 16'h0000},
    {4'd3,  16'h0F0F, 16'h00FF, 16'h000F},
    {4'd4,  16'h0F00, 16'h00F0, 16'h0FF0},
    {4'd5,  16'h00FF, 16'h0F0F, 16'h0FF0},
    {4'd6,  16'h0000, 16'h1234, 16'hEDCB},
    {4'd7,  16'h0005, 16'h0005, 16'hFFFF},
    {4'd7,  16'h0005, 16'h0006, 16'h0000},
    {4'd8,  16'hFFFE, 16'h0001, 16'hFFFF},
    {4'd8,  16'h0001, 16'hFFFE, 16'h0000},
    {4'd15, 16'hFFFE, 16'h0001, 16'h0000},
    {4'd15, 16'h0001, 16'hFFFE, 16'hFFFF},
    {4'd9,  16'h8000, 16'h0004, 16'h0800},
    {4'd13, 16'h0001, 16'h000F, 16'h8000},
    {4'd10, 16'h0000, 16'h0000, 16'hFFFF},
    {4'd1,  16'h0007, 16'h0009, 16'h0007}
  };

  initial begin
    // R1: reset state, while loading
    plen = 0;
    emit(lit(15'h0005));
    emit(jmp(13'd1));
    load_prog();
    chk("R1 pc in reset", 32'(pc), 32'h0);
    chk("R1 tos in reset", 32'(tos), 32'h0);

    // R7: vector walk (binary ops pop one: dd=11)
    for (int v = 0; v < 16; v++) begin
      plen = 0;
      push_val(VEC[v][47:32]);
      push_val(VEC[v][31:16]);
      emit(alu(VEC[v][51:48], 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11));
      emit(jmp(13'(plen)));
      run(12);
      chk($sformatf("R7 op%0d vec%0d", VEC[v][51:48], v), 32'(tos), 32'(VEC[v][15:0]));
    end

    // R1 R12: pointer cleared by reset, depth read
    plen = 0;
    emit(alu(4'd14, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00));
    emit(jmp(13'd1));
    run(6);
    chk("R1 R12 depth after reset", 32'(tos), 32'h0);

    plen = 0;
    emit(lit(15'd1)); emit(lit(15'd2)); emit(lit(15'd3));
    emit(alu(4'd14, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00));
    emit(jmp(13'd4));
    run(8);
    chk("R12 depth three pushes", 32'(tos), 32'd3);

    plen = 0;
    emit(alu(4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11));
    emit(alu(4'd14, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00));
    emit(jmp(13'd2));
    run(6);
    chk("R12 underflow wrap", 32'(tos), 32'd31);

    // R5 R6 R13: call / folded return, step by step
    plen = 0;
    emit(call(13'd4)); emit(lit(15'd7)); emit(jmp(13'd2)); emit(jmp(13'd3));
    emit(lit(15'd5));
    emit(alu(4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b00));
    run(1);
    chk("R5 call target in one cycle", 32'(pc), 32'd4);
    @(negedge clk);
    chk("R13 next pc", 32'(pc), 32'd5);
    @(negedge clk);
    chk("R6 return lands at call+1", 32'(pc), 32'd1);
    @(negedge clk);
    chk("R13 after return", 32'(pc), 32'd2);
    chk("R2 literal after return", 32'(tos), 32'd7);

    // R3: jump
    plen = 0;
    emit(jmp(13'd6));
    for (int i = 1; i < 6; i++) emit(lit(15'h0077));
    emit(lit(15'h0011)); emit(jmp(13'd7));
    run(6);
    chk("R3 jump skips", 32'(tos), 32'h11);
    chk("R3 jump self", 32'(pc), 32'd7);

    // R4: conditional jump taken / not taken
    plen = 0;
    emit(lit(15'd9)); emit(lit(15'd0)); emit(cjmp(13'd5)); emit(lit(15'd1));
    emit(jmp(13'd4)); emit(lit(15'd2)); emit(jmp(13'd6));
    run(8);
    chk("R4 taken tos", 32'(tos), 32'd2);
    chk("R4 taken pc", 32'(pc), 32'd6);
    prog[1] = lit(15'd3);
    run(8);
    chk("R4 not taken tos", 32'(tos), 32'd1);
    chk("R4 not taken pc", 32'(pc), 32'd4);

    // R8: dup via T->N + push, then add with pop
    plen = 0;
    emit(lit(15'd21));
    emit(alu(4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01));
    emit(alu(4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11));
    emit(jmp(13'd3));
    run(6);
    chk("R8 dup add", 32'(tos), 32'd42);

    // R9: T->R then read R
    plen = 0;
    emit(lit(15'h0042));
    emit(alu(4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00));
    emit(lit(15'd0));
    emit(alu(4'd11, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01));
    emit(jmp(13'd4));
    run(8);
    chk("R9 return stack read", 32'(tos), 32'h42);

    // R10: store then fetch after re-addressing
    plen = 0;
    emit(lit(15'h0123)); emit(lit(15'd100));
    emit(alu(4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b11));
    emit(lit(15'd100));
    emit(alu(4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00));
    emit(jmp(13'd5));
    run(9);
    chk("R10 ram store/fetch", 32'(tos), 32'h0123);

    // R11: I/O diversion, RAM word 0 untouched
    plen = 0;
    emit(lit(15'h0055)); emit(lit(15'h7FFF));
    emit(alu(4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00));
    emit(alu(4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b11));
    emit(lit(15'd0));
    emit(alu(4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00));
    emit(jmp(13'd6));
    load_prog();
    io_cnt = 0;
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 io strobe count", 32'(io_cnt), 32'd1);
    chk("R11 io addr", 32'(io_a), 32'h0);
    chk("R11 io data", 32'(io_d), 32'h55);
    chk("R11 ram word0 kept", 32'(tos), 32'h8055);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total = total + 1;
    bad   = bad + 1;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule